// File: doc/BRIEF.md
# General Register File with Delayed Load Writeback

This block holds the general registers of an in-order processor whose loads carry a one-instruction delay slot, with no interlock. It offers two operand read ports, an immediate write port for results that retire at once, and a delayed write port for load data. A delayed write is parked in a staging slot. At the next instruction boundary it moves to a pending slot. At the boundary after that it reaches the array. The instruction that sits in the delay slot therefore still reads the old register value.

The core marks the end of each instruction with a one-cycle `step_i` pulse. `flush_i` empties the pipeline when an exception or redirect occurs. A third read port serves loads that merge new bytes into a partly loaded register: when its index matches the pending delayed write, it returns the pending value instead of the array contents. All read data is registered. The value on a read output is the register state just before the clock edge at which the index was sampled.

Top module: `gpr_ldelay_file`

## Requirements
- R1: Index 0 always reads as zero on every read port. Immediate and delayed writes to index 0 have no effect.
- R2: Each read output shows, one cycle after its index is presented, the register contents as they were before that clock edge.
- R3: An immediate write to a non-zero index is seen by a read presented in the following cycle.
- R4: A delayed write issued during an instruction, including in the cycle of its own step, becomes pending at that step. The register keeps its old value through the whole next instruction. The new value appears only after the step that ends that next instruction.
- R5: An immediate write to the register named by the pending delayed write cancels that pending write. The register keeps the immediate value after the next step.
- R6: A new delayed write to the register named by the pending one drops the earlier pending value. Only the later value reaches the register.
- R7: A flush writes the pending delayed value into the array at once. It discards the staged write, including one issued in the same cycle, and leaves nothing pending.
- R8: The merge read port returns the pending delayed value when its index matches the pending register. Otherwise it returns the register contents, with zero for index 0.
- R9: At most one delayed write is issued per instruction. A second issue before the next step is a protocol violation.
- R10: When flush and step arrive in the same cycle, the flush behaviour applies and no staged write becomes pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | End of the current instruction |
| flush_i | input | 1 | Pipeline flush |
| wr_en_i | input | 1 | Immediate write enable |
| wr_idx_i | input | 5 | Immediate write register index |
| wr_data_i | input | 32 | Immediate write data |
| ld_en_i | input | 1 | Delayed write issue |
| ld_idx_i | input | 5 | Delayed write register index |
| ld_data_i | input | 32 | Delayed write data |
| rs_idx_i | input | 5 | First operand read index |
| rs_data_o | output | 32 | First operand read data (registered) |
| rt_idx_i | input | 5 | Second operand read index |
| rt_data_o | output | 32 | Second operand read data (registered) |
| mg_idx_i | input | 5 | Merge read index |
| mg_data_o | output | 32 | Merge read data with pending-value bypass |

## Verification
The bench targets the delay slot itself. A design that commits too early would show the new load value to the instruction in the slot, and one that commits too late would still show the old value one instruction after that. It also sets up the two cancellations. If an immediate write failed to cancel the pending load, the stale load value would overwrite the newer result. If a second load to the same register failed to drop the first, the earlier data would surface for one instruction. Flush, alone and together with a step, is checked for a lost pending value or a staged write that slips through. Writes to index 0 and merge reads of a register that is not pending are hit by random traffic over a narrow index range, where collisions are frequent.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned GPR_COUNT_DEF = 32;
  localparam int unsigned GPR_WIDTH_DEF = 32;
endpackage

// File: rtl/gpr_array.sv
module gpr_array #(
  parameter int unsigned NREGS = gpr_pkg::GPR_COUNT_DEF,
  parameter int unsigned DW    = gpr_pkg::GPR_WIDTH_DEF,
  parameter int unsigned NRD   = 3,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wa_en,
  input  logic [AW-1:0]           wa_idx,
  input  logic [DW-1:0]           wa_data,
  input  logic                    wb_en,
  input  logic [AW-1:0]           wb_idx,
  input  logic [DW-1:0]           wb_data,
  input  logic [NRD-1:0][AW-1:0]  rd_idx,
  output logic [NRD-1:0][DW-1:0]  rd_data
);
  logic [DW-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (wa_en && wa_idx != '0) mem[wa_idx] <= wa_data;
    if (wb_en && wb_idx != '0) mem[wb_idx] <= wb_data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst)                    rd_data[g] <= '0;
      else if (rd_idx[g] == '0)   rd_data[g] <= '0;
      else                        rd_data[g] <= mem[rd_idx[g]];
    end

    a_r1_zero_read: assert property (@(posedge clk) disable iff (rst)
      (rd_idx[g] == '0) |=> (rd_data[g] == '0));
  end

  // R5: a cancelled pending write never collides with the immediate write
  a_r5_single_writer: assert property (@(posedge clk) disable iff (rst)
    (wa_en && wb_en) |-> (wa_idx != wb_idx));
endmodule

// File: rtl/gpr_delay_ctrl.sv
module gpr_delay_ctrl #(
  parameter int unsigned NREGS = gpr_pkg::GPR_COUNT_DEF,
  parameter int unsigned DW    = gpr_pkg::GPR_WIDTH_DEF,
  localparam int unsigned AW   = $clog2(NREGS),
  localparam int unsigned TW   = AW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step,
  input  logic           flush,
  input  logic           we_en,
  input  logic [AW-1:0]  we_idx,
  input  logic           ld_en,
  input  logic [AW-1:0]  ld_idx,
  input  logic [DW-1:0]  ld_data,
  input  logic [AW-1:0]  mg_idx,
  output logic           cm_en,
  output logic [AW-1:0]  cm_idx,
  output logic [DW-1:0]  cm_data,
  output logic           mg_hit,
  output logic [DW-1:0]  mg_val
);
  localparam logic [TW-1:0] EMPTY = TW'(NREGS);

  logic [TW-1:0] pnd_tag, stg_tag;
  logic [DW-1:0] pnd_val, stg_val;

  logic pnd_live, stg_live, kill_by_wr, kill_by_ld, pnd_keep, ld_take;

  assign pnd_live   = (pnd_tag != EMPTY);
  assign stg_live   = (stg_tag != EMPTY);
  assign kill_by_wr = we_en && ({1'b0, we_idx} == pnd_tag);
  assign kill_by_ld = ld_en && ({1'b0, ld_idx} == pnd_tag);
  assign pnd_keep   = pnd_live && !kill_by_wr && !kill_by_ld;
  assign ld_take    = ld_en && (ld_idx != '0);

  assign cm_en   = (step || flush) && pnd_keep;
  assign cm_idx  = pnd_tag[AW-1:0];
  assign cm_data = pnd_val;
  assign mg_hit  = ({1'b0, mg_idx} == pnd_tag);
  assign mg_val  = pnd_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      pnd_tag <= EMPTY;
      stg_tag <= EMPTY;
      pnd_val <= '0;
      stg_val <= '0;
    end else if (flush) begin
      pnd_tag <= EMPTY;
      stg_tag <= EMPTY;
    end else if (step) begin
      if (ld_take) begin
        pnd_tag <= {1'b0, ld_idx};
        pnd_val <= ld_data;
      end else begin
        pnd_tag <= stg_tag;
        pnd_val <= stg_val;
      end
      stg_tag <= EMPTY;
    end else begin
      if (!pnd_keep) pnd_tag <= EMPTY;
      if (ld_take) begin
        stg_tag <= {1'b0, ld_idx};
        stg_val <= ld_data;
      end
    end
  end

  a_r1_no_zero_pending: assert property (@(posedge clk) disable iff (rst)
    pnd_tag != '0);
  a_r9_one_issue: assert property (@(posedge clk) disable iff (rst)
    ld_en |-> !stg_live);
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!pnd_live && !stg_live));
  a_r4_stage_advances: assert property (@(posedge clk) disable iff (rst)
    (step && !flush && !ld_en) |=> (pnd_tag == $past(stg_tag) && !stg_live));
  a_r5_cancel_on_write: assert property (@(posedge clk) disable iff (rst)
    (pnd_live && kill_by_wr && !step && !flush) |=> !pnd_live);
endmodule

// File: rtl/gpr_ldelay_file.sv
module gpr_ldelay_file #(
  parameter int unsigned NREGS = gpr_pkg::GPR_COUNT_DEF,
  parameter int unsigned DW    = gpr_pkg::GPR_WIDTH_DEF,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_i,
  input  logic           flush_i,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_idx_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic           ld_en_i,
  input  logic [AW-1:0]  ld_idx_i,
  input  logic [DW-1:0]  ld_data_i,
  input  logic [AW-1:0]  rs_idx_i,
  output logic [DW-1:0]  rs_data_o,
  input  logic [AW-1:0]  rt_idx_i,
  output logic [DW-1:0]  rt_data_o,
  input  logic [AW-1:0]  mg_idx_i,
  output logic [DW-1:0]  mg_data_o
);
  localparam int unsigned NRD = 3;

  logic           cm_en, mg_hit, mg_hit_q;
  logic [AW-1:0]  cm_idx;
  logic [DW-1:0]  cm_data, mg_val, mg_val_q;
  logic [NRD-1:0][AW-1:0] rd_idx;
  logic [NRD-1:0][DW-1:0] rd_data;

  assign rd_idx = {mg_idx_i, rt_idx_i, rs_idx_i};

  gpr_delay_ctrl #(.NREGS(NREGS), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .step(step_i), .flush(flush_i),
    .we_en(wr_en_i), .we_idx(wr_idx_i),
    .ld_en(ld_en_i), .ld_idx(ld_idx_i), .ld_data(ld_data_i),
    .mg_idx(mg_idx_i),
    .cm_en(cm_en), .cm_idx(cm_idx), .cm_data(cm_data),
    .mg_hit(mg_hit), .mg_val(mg_val)
  );

  gpr_array #(.NREGS(NREGS), .DW(DW), .NRD(NRD)) u_array (
    .clk(clk), .rst(rst),
    .wa_en(wr_en_i), .wa_idx(wr_idx_i), .wa_data(wr_data_i),
    .wb_en(cm_en), .wb_idx(cm_idx), .wb_data(cm_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mg_hit_q <= 1'b0;
      mg_val_q <= '0;
    end else begin
      mg_hit_q <= mg_hit;
      mg_val_q <= mg_val;
    end
  end

  assign rs_data_o = rd_data[0];
  assign rt_data_o = rd_data[1];
  assign mg_data_o = mg_hit_q ? mg_val_q : rd_data[2];

  // R8: a bypass hit never names index 0
  a_r8_bypass_nonzero: assert property (@(posedge clk) disable iff (rst)
    mg_hit |-> (mg_idx_i != '0));
endmodule

// File: tb/gpr_ldelay_file_tb.sv
module gpr_ldelay_file_tb;
  localparam int unsigned NREGS = 32;
  localparam int unsigned DW    = 32;
  localparam int unsigned AW    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_i = 0, flush_i = 0, wr_en_i = 0, ld_en_i = 0;
  logic [AW-1:0] wr_idx_i = '0, ld_idx_i = '0, rs_idx_i = '0, rt_idx_i = '0, mg_idx_i = '0;
  logic [DW-1:0] wr_data_i = '0, ld_data_i = '0;
  logic [DW-1:0] rs_data_o, rt_data_o, mg_data_o;

  always #5 clk = ~clk;

  gpr_ldelay_file u_dut (
    .clk(clk), .rst(rst), .step_i(step_i), .flush_i(flush_i),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .ld_en_i(ld_en_i), .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i),
    .rs_idx_i(rs_idx_i), .rs_data_o(rs_data_o),
    .rt_idx_i(rt_idx_i), .rt_data_o(rt_data_o),
    .mg_idx_i(mg_idx_i), .mg_data_o(mg_data_o)
  );

  int total = 0;
  int bad = 0;

  // reference state
  logic [DW-1:0] m [NREGS];
  logic          pv, nv;
  int            pi, ni;
  logic [DW-1:0] pd, nd;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] rd_exp(input int idx);
    return (idx == 0) ? '0 : m[idx];
  endfunction

  // one clock with the given stimulus; checks all three read outputs
  task automatic cyc(input string req,
                     input logic we, input int wi, input logic [DW-1:0] wd,
                     input logic le, input int li, input logic [DW-1:0] ldv,
                     input logic st, input logic fl,
                     input int ra, input int rb, input int rm);
    logic [DW-1:0] ea, eb, em;
    logic pkeep;
    wr_en_i = we; wr_idx_i = AW'(wi); wr_data_i = wd;
    ld_en_i = le; ld_idx_i = AW'(li); ld_data_i = ldv;
    step_i = st; flush_i = fl;
    rs_idx_i = AW'(ra); rt_idx_i = AW'(rb); mg_idx_i = AW'(rm);
    ea = rd_exp(ra);
    eb = rd_exp(rb);
    em = (pv && pi == rm) ? pd : rd_exp(rm);
    pkeep = pv && !(we && wi == pi) && !(le && li == pi);
    @(posedge clk);
    if (we && wi != 0) m[wi] = wd;
    if ((st || fl) && pkeep) m[pi] = pd;
    if (fl) begin
      pv = 0; nv = 0;
    end else if (st) begin
      if (le && li != 0) begin pv = 1; pi = li; pd = ldv; end
      else begin pv = nv; pi = ni; pd = nd; end
      nv = 0;
    end else begin
      pv = pkeep;
      if (le && li != 0) begin nv = 1; ni = li; nd = ldv; end
    end
    #2;
    chk({req, " rs"}, rs_data_o, ea);
    chk({req, " rt"}, rt_data_o, eb);
    chk({req, " mg"}, mg_data_o, em);
    wr_en_i = 0; ld_en_i = 0; step_i = 0; flush_i = 0;
  endtask

  task automatic rd(input string req, input int r);
    cyc(req, 0, 0, '0, 0, 0, '0, 0, 0, r, r, r);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    pv = 0; nv = 0; pi = 0; ni = 0; pd = '0; nd = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    chk("reset R2 rs", rs_data_o, '0);
    chk("reset R2 mg", mg_data_o, '0);
    rst = 0;

    for (int r = 0; r < NREGS; r++) begin
      m[r] = '0;
      cyc("init R3", 1, r, DW'(r * 32'h01010101), 0, 0, '0, 0, 0, 0, 0, 0);
    end
    m[0] = '0;
    for (int r = 1; r < 4; r++) rd("R3 readback", r);

    // R1: writes to index 0 do nothing
    cyc("R1 wr0", 1, 0, 32'hdeadbeef, 1, 0, 32'hcafef00d, 1, 0, 0, 0, 0);
    cyc("R1 after", 0, 0, '0, 0, 0, '0, 1, 0, 0, 0, 0);
    rd("R1 zero", 0);
    chk("R1 literal", rs_data_o, 32'h0);

    // R4: delay slot sees old value
    cyc("R4 issue", 0, 0, '0, 1, 5, 32'haaaa5555, 1, 0, 5, 5, 0);
    cyc("R4 slot", 0, 0, '0, 0, 0, '0, 1, 0, 5, 0, 5);
    chk("R4 slot old", rs_data_o, 32'h05050505);
    chk("R8 merge pending", mg_data_o, 32'haaaa5555);
    rd("R4 visible", 5);
    chk("R4 new value", rs_data_o, 32'haaaa5555);

    // R5: immediate write cancels pending
    cyc("R5 issue", 0, 0, '0, 1, 6, 32'h11112222, 1, 0, 0, 0, 0);
    cyc("R5 wr", 1, 6, 32'h33334444, 0, 0, '0, 1, 0, 0, 0, 0);
    rd("R5 result", 6);
    chk("R5 literal", rs_data_o, 32'h33334444);

    // R6: second load to same register drops the first
    cyc("R6 first", 0, 0, '0, 1, 7, 32'h0000aaaa, 1, 0, 0, 0, 0);
    cyc("R6 second", 0, 0, '0, 1, 7, 32'h0000bbbb, 1, 0, 7, 0, 7);
    chk("R6 no early", rs_data_o, 32'h07070707);
    cyc("R6 slot", 0, 0, '0, 0, 0, '0, 1, 0, 7, 0, 0);
    chk("R6 first dropped", rs_data_o, 32'h07070707);
    rd("R6 final", 7);
    chk("R6 literal", rs_data_o, 32'h0000bbbb);

    // R7: flush commits pending, drops staged
    cyc("R7 issue", 0, 0, '0, 1, 8, 32'h88888888, 1, 0, 0, 0, 0);
    cyc("R7 stage", 0, 0, '0, 1, 9, 32'h99999999, 0, 0, 0, 0, 0);
    cyc("R7 flush", 0, 0, '0, 0, 0, '0, 0, 1, 0, 0, 0);
    cyc("R7 read", 0, 0, '0, 0, 0, '0, 1, 0, 8, 9, 9);
    chk("R7 committed", rs_data_o, 32'h88888888);
    chk("R7 discarded", rt_data_o, 32'h09090909);
    rd("R7 later", 9);
    chk("R7 still old", rs_data_o, 32'h09090909);

    // R10: flush with step and same-cycle issue
    cyc("R10 issue", 0, 0, '0, 1, 10, 32'habababab, 1, 1, 0, 0, 0);
    cyc("R10 step", 0, 0, '0, 0, 0, '0, 1, 0, 0, 0, 10);
    rd("R10 read", 10);
    chk("R10 literal", rs_data_o, 32'h0a0a0a0a);

    // random traffic over a narrow index range
    for (int i = 0; i < 4000; i++) begin
      logic we, le, st, fl;
      int wi, li, ra, rb, rm;
      logic [DW-1:0] wd, ldv;
      we = ($urandom % 3) == 0;
      le = !nv && (($urandom % 3) == 0);
      st = ($urandom % 2) == 0;
      fl = ($urandom % 20) == 0;
      wi = $urandom % 8; li = $urandom % 8;
      ra = $urandom % 8; rb = $urandom % 8; rm = $urandom % 8;
      wd = $urandom; ldv = $urandom;
      cyc("R2 R3 R4 R5 R6 R7 R8 random", we, wi, wd, le, li, ldv, st, fl, ra, rb, rm);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule